// File: doc/BRIEF.md
# Ping-Pong Transmit Buffer Ownership Tracker

This block keeps the ownership record for a small set of transmit packet buffers (two by default) that an upper-level producer and a lower-level consumer share. The producer fills a buffer and then posts a hand-over event carrying the buffer's index. The consumer transmits that buffer and then posts a return event carrying the same index. Because ownership passes per buffer, the producer can fill one buffer while the consumer is still transmitting the other.

The tracker shows the producer a mask of the buffers it may fill. It shows the consumer the index of the oldest handed-over buffer, which is the next one to transmit. It raises a one-cycle completion notification toward the producer when a return is accepted. Write strobes from both sides pass through the tracker. A strobe from the side that does not own the addressed buffer is blocked and counted. A hand-over or return that breaks the ownership protocol sets a sticky error flag and changes no state.

Top module: `txbuf_owner_tracker`

## Requirements
- R1: After a synchronous reset every buffer is producer-owned (`prod_free` all ones). `cons_valid` is 0, `proto_err` is 0, `viol_cnt` is 0 and `done_pulse` is 0.
- R2: A hand-over (`post_valid`) for a producer-owned buffer makes that buffer consumer-owned from the next cycle. Its bit in `prod_free` (bit i is buffer i) reads 0, and `cons_valid` reads 1.
- R3: `cons_idx` always names the oldest pending handed-over buffer. A second hand-over that arrives while one is still pending is queued behind it and is not dropped.
- R4: A return (`ret_valid`) whose index equals `cons_idx` while `cons_valid` is 1 makes that buffer producer-owned from the next cycle. `cons_idx` then advances to the next pending buffer, or `cons_valid` falls to 0 if none is pending.
- R5: Each accepted return drives `done_pulse` high for exactly one cycle, the cycle after the return, with `done_pulse_idx` equal to the returned index.
- R6: A hand-over for a buffer the consumer already owns sets `proto_err` and leaves every buffer's ownership unchanged.
- R7: A return for a producer-owned buffer, or for a consumer-owned buffer that is not `cons_idx`, sets `proto_err`, leaves ownership unchanged and produces no `done_pulse`.
- R8: `proto_err` stays at 1 until reset.
- R9: `prod_wr_ok` is `prod_wr_en` gated by producer ownership of `prod_wr_idx`, and `cons_wr_ok` is `cons_wr_en` gated by consumer ownership of `cons_wr_idx`. Both are combinational in the same cycle.
- R10: Each blocked strobe adds 1 to `viol_cnt` at the next edge, so blocked strobes on both sides in one cycle add 2. `viol_cnt` saturates at its maximum (255 by default) and never decreases.
- R11: A hand-over and a return in the same cycle are both judged against the ownership that held before that edge, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Producer hands a buffer to the consumer |
| post_idx | input | IDX_W | Index of the handed-over buffer |
| ret_valid | input | 1 | Consumer returns a buffer after transmission |
| ret_idx | input | IDX_W | Index of the returned buffer |
| prod_wr_en | input | 1 | Producer write strobe |
| prod_wr_idx | input | IDX_W | Buffer addressed by the producer write |
| cons_wr_en | input | 1 | Consumer write strobe |
| cons_wr_idx | input | IDX_W | Buffer addressed by the consumer write |
| prod_wr_ok | output | 1 | Producer write allowed through |
| cons_wr_ok | output | 1 | Consumer write allowed through |
| prod_free | output | NBUF | Bit i set when buffer i is producer-owned |
| cons_valid | output | 1 | A handed-over buffer is waiting for the consumer |
| cons_idx | output | IDX_W | Oldest pending buffer for the consumer |
| done_pulse | output | 1 | Completion notification to the producer |
| done_pulse_idx | output | IDX_W | Buffer named by the completion notification |
| proto_err | output | 1 | Sticky protocol error |
| viol_cnt | output | CNT_W | Saturating count of blocked write strobes |

## Verification
The bench covers several corner cases. One is a return of the second-queued buffer while the first is still pending: a tracker that accepts returns for any consumer-owned buffer would release the wrong buffer and send a stray completion. Another is a hand-over of a busy buffer: a design that re-pushes it would queue the same index twice. A third is a hand-over and a return in the same cycle, which catches designs that judge one event against the state the other has just produced. The bench also drives blocked strobes on both sides at once and holds them long enough to reach saturation, which exposes a counter that counts only one violation per cycle or wraps to zero.

// File: rtl/txo_pkg.sv
package txo_pkg;

    typedef enum logic {
        OWN_PROD = 1'b0,
        OWN_CONS = 1'b1
    } owner_e;

    // Saturating add of a small increment to an unsigned counter value
    function automatic logic [31:0] sat_add(input logic [31:0] val,
                                            input logic [1:0]  inc,
                                            input logic [31:0] maxv);
        logic [32:0] sum;
        sum = {1'b0, val} + {31'd0, inc};
        if (sum > {1'b0, maxv}) return maxv;
        return sum[31:0];
    endfunction

endpackage

// File: rtl/txo_owner_bank.sv
module txo_owner_bank
    import txo_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NBUF-1:0] take_mask,
    input  logic [NBUF-1:0] give_mask,
    output logic [NBUF-1:0] cons_mask
);
    owner_e state_q [NBUF];

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst)               state_q[i] <= OWN_PROD;
            else if (take_mask[i]) state_q[i] <= OWN_CONS;
            else if (give_mask[i]) state_q[i] <= OWN_PROD;
        end
        assign cons_mask[i] = (state_q[i] == OWN_CONS);
    end
endmodule

// File: rtl/txo_order_fifo.sv
module txo_order_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         nonempty,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [PTR_W:0]   cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign nonempty = (cnt_q != '0);
    assign head     = mem[rd_q];
endmodule

// File: rtl/txo_viol_counter.sv
module txo_viol_counter
    import txo_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [31:0] MAXV = 32'((64'd1 << CNT_W) - 1);
    logic [31:0] next_val;

    always_comb next_val = sat_add(32'(count), inc, MAXV);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= next_val[CNT_W-1:0];
    end
endmodule

// File: rtl/txbuf_owner_tracker.sv
module txbuf_owner_tracker #(
    parameter int NBUF  = 2,
    parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_valid,
    input  logic [IDX_W-1:0] post_idx,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    input  logic             prod_wr_en,
    input  logic [IDX_W-1:0] prod_wr_idx,
    input  logic             cons_wr_en,
    input  logic [IDX_W-1:0] cons_wr_idx,
    output logic             prod_wr_ok,
    output logic             cons_wr_ok,
    output logic [NBUF-1:0]  prod_free,
    output logic             cons_valid,
    output logic [IDX_W-1:0] cons_idx,
    output logic             done_pulse,
    output logic [IDX_W-1:0] done_pulse_idx,
    output logic             proto_err,
    output logic [CNT_W-1:0] viol_cnt
);
    localparam logic [IDX_W:0] NB = (IDX_W + 1)'(NBUF);

    logic [NBUF-1:0] cons_mask, take_mask, give_mask;
    logic            post_ok, ret_ok, prod_bad, cons_bad;

    function automatic logic in_range(input logic [IDX_W-1:0] idx);
        return {1'b0, idx} < NB;
    endfunction

    function automatic logic prod_has(input logic [IDX_W-1:0] idx,
                                      input logic [NBUF-1:0] cm);
        return in_range(idx) && !cm[idx];
    endfunction

    function automatic logic cons_has(input logic [IDX_W-1:0] idx,
                                      input logic [NBUF-1:0] cm);
        return in_range(idx) && cm[idx];
    endfunction

    // Event acceptance, judged against the state before the edge
    always_comb begin
        post_ok = post_valid && prod_has(post_idx, cons_mask);
        ret_ok  = ret_valid && cons_valid && (ret_idx == cons_idx)
                  && cons_has(ret_idx, cons_mask);
        for (int i = 0; i < NBUF; i++) begin
            take_mask[i] = post_ok && (post_idx == IDX_W'(i));
            give_mask[i] = ret_ok  && (ret_idx  == IDX_W'(i));
        end
    end

    // Write strobe gating
    always_comb begin
        prod_wr_ok = prod_wr_en && prod_has(prod_wr_idx, cons_mask);
        cons_wr_ok = cons_wr_en && cons_has(cons_wr_idx, cons_mask);
        prod_bad   = prod_wr_en && !prod_wr_ok;
        cons_bad   = cons_wr_en && !cons_wr_ok;
    end

    txo_owner_bank #(.NBUF(NBUF)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .take_mask (take_mask),
        .give_mask (give_mask),
        .cons_mask (cons_mask)
    );

    txo_order_fifo #(.DEPTH(NBUF), .W(IDX_W)) u_order (
        .clk      (clk),
        .rst      (rst),
        .push     (post_ok),
        .din      (post_idx),
        .pop      (ret_ok),
        .nonempty (cons_valid),
        .head     (cons_idx)
    );

    txo_viol_counter #(.CNT_W(CNT_W)) u_viol (
        .clk   (clk),
        .rst   (rst),
        .inc   ({1'b0, prod_bad} + {1'b0, cons_bad}),
        .count (viol_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_pulse     <= 1'b0;
            done_pulse_idx <= '0;
            proto_err      <= 1'b0;
        end else begin
            done_pulse <= ret_ok;
            if (ret_ok) done_pulse_idx <= ret_idx;
            if ((post_valid && !post_ok) || (ret_valid && !ret_ok))
                proto_err <= 1'b1;
        end
    end

    assign prod_free = ~cons_mask;
endmodule

// File: rtl/txo_checker.sv
module txo_checker #(
    parameter int NBUF  = 2,
    parameter int IDX_W = 1,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             prod_wr_ok,
    input logic             cons_wr_ok,
    input logic [IDX_W-1:0] prod_wr_idx,
    input logic [IDX_W-1:0] cons_wr_idx,
    input logic [NBUF-1:0]  prod_free,
    input logic             cons_valid,
    input logic [IDX_W-1:0] cons_idx,
    input logic             done_pulse,
    input logic [IDX_W-1:0] done_pulse_idx,
    input logic             proto_err,
    input logic [CNT_W-1:0] viol_cnt
);
    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R10
    viol_mono_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 (viol_cnt >= $past(viol_cnt)));

    // R3
    head_owned_chk: assert property (@(posedge clk) disable iff (rst)
        cons_valid |-> !prod_free[cons_idx]);

    // R9
    excl_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (prod_wr_ok && cons_wr_ok) |-> (prod_wr_idx != cons_wr_idx));

    // R5
    done_free_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> prod_free[done_pulse_idx]);
endmodule

bind txbuf_owner_tracker txo_checker #(
    .NBUF(NBUF), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .prod_wr_ok     (prod_wr_ok),
    .cons_wr_ok     (cons_wr_ok),
    .prod_wr_idx    (prod_wr_idx),
    .cons_wr_idx    (cons_wr_idx),
    .prod_free      (prod_free),
    .cons_valid     (cons_valid),
    .cons_idx       (cons_idx),
    .done_pulse     (done_pulse),
    .done_pulse_idx (done_pulse_idx),
    .proto_err      (proto_err),
    .viol_cnt       (viol_cnt)
);

// File: tb/sim_txbuf_owner_tracker.sv
module sim_txbuf_owner_tracker;
    localparam int NBUF = 2, IDX_W = 1, CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic post_valid = 0, ret_valid = 0, prod_wr_en = 0, cons_wr_en = 0;
    logic [IDX_W-1:0] post_idx = 0, ret_idx = 0, prod_wr_idx = 0, cons_wr_idx = 0;
    logic prod_wr_ok, cons_wr_ok, cons_valid, done_pulse, proto_err;
    logic [NBUF-1:0]  prod_free;
    logic [IDX_W-1:0] cons_idx, done_pulse_idx;
    logic [CNT_W-1:0] viol_cnt;

    int checks = 0, failures = 0;
    int exp_q[$];
    bit finished = 0;

    always #10 clk = ~clk;

    txbuf_owner_tracker #(.NBUF(NBUF), .IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic post(input int idx);
        post_valid = 1'b1;
        post_idx   = IDX_W'(idx);
        tick();
        post_valid = 1'b0;
    endtask

    // Driver: an accepted return pushes the expected completion
    task automatic ret(input int idx, input bit accepted);
        ret_valid = 1'b1;
        ret_idx   = IDX_W'(idx);
        if (accepted) exp_q.push_back(idx);
        tick();
        ret_valid = 1'b0;
    endtask

    // Monitor: every completion pulse must match the oldest expected item
    always @(posedge clk) begin
        #2;
        if (!rst && done_pulse) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R5 actual=pulse idx %0d expected=no pulse", done_pulse_idx);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(done_pulse_idx) != e) begin
                    failures++;
                    $display("FAIL R5 actual=%0d expected=%0d", done_pulse_idx, e);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 prod_free", prod_free, 3);
        chk("R1 cons_valid", cons_valid, 0);
        chk("R1 proto_err", proto_err, 0);
        chk("R1 viol_cnt", viol_cnt, 0);
        chk("R1 done_pulse", done_pulse, 0);

        // R2 hand over buffer 0
        post(0);
        chk("R2 prod_free", prod_free, 2);
        chk("R2 cons_valid", cons_valid, 1);
        chk("R2 cons_idx", cons_idx, 0);

        // R3 second hand-over queued behind the first
        post(1);
        chk("R3 prod_free", prod_free, 0);
        chk("R3 cons_idx oldest", cons_idx, 0);

        // R9 gating, R10 single violation
        prod_wr_en = 1; prod_wr_idx = 0;
        cons_wr_en = 1; cons_wr_idx = 0;
        #1;
        chk("R9 prod blocked", prod_wr_ok, 0);
        chk("R9 cons allowed", cons_wr_ok, 1);
        tick();
        prod_wr_en = 0; cons_wr_en = 0;
        chk("R10 one violation", viol_cnt, 1);

        // R7 out-of-order return of buffer 1
        ret(1, 0);
        chk("R7 out-of-order err", proto_err, 1);
        chk("R7 prod_free kept", prod_free, 0);
        chk("R7 cons_idx kept", cons_idx, 0);

        do_reset();
        chk("R8 err cleared by reset", proto_err, 0);

        post(0);
        post(1);
        // R4 return head, advance to buffer 1
        ret(0, 1);
        chk("R4 prod_free", prod_free, 1);
        chk("R4 cons_idx advance", cons_idx, 1);
        chk("R5 pulse idx", done_pulse_idx, 0);
        tick();
        chk("R5 single-cycle pulse", done_pulse, 0);
        prod_wr_en = 1; prod_wr_idx = 0;
        #1;
        chk("R9 prod allowed after return", prod_wr_ok, 1);
        prod_wr_en = 0;

        // R6 hand-over of a busy buffer
        post(1);
        chk("R6 err", proto_err, 1);
        chk("R6 prod_free kept", prod_free, 1);
        ret(1, 1);
        chk("R6 no duplicate queued", cons_valid, 0);
        tick(); tick();
        chk("R8 err sticky", proto_err, 1);

        // R7 return of producer-owned buffer
        do_reset();
        ret(0, 0);
        chk("R7 producer-owned err", proto_err, 1);
        chk("R7 prod_free", prod_free, 3);

        // R11 same-cycle hand-over and return
        do_reset();
        post(0);
        post_valid = 1; post_idx = 1;
        ret_valid = 1; ret_idx = 0; exp_q.push_back(0);
        tick();
        post_valid = 0; ret_valid = 0;
        chk("R11 prod_free", prod_free, 1);
        chk("R11 cons_idx", cons_idx, 1);
        chk("R11 no err", proto_err, 0);

        // R10 double violation and saturation
        do_reset();
        post(0);
        prod_wr_en = 1; prod_wr_idx = 0;
        cons_wr_en = 1; cons_wr_idx = 1;
        tick();
        chk("R10 two per cycle", viol_cnt, 2);
        for (int k = 0; k < 130; k++) tick();
        chk("R10 saturate", viol_cnt, 255);
        tick();
        chk("R10 hold at max", viol_cnt, 255);
        prod_wr_en = 0; cons_wr_en = 0;

        tick();
        chk("R5 all completions seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule